// File: doc/BRIEF.md
# Expansion ROM Base Address Register with Run-Time Window Size

This block holds the base address register through which a bus device claims memory space for an option ROM. The size of the claimed window is not set when the design is built. It depends on a 16-bit size mask, and each address bit that the mask leaves at 0 is forced to 0 and cannot be written. A wider run of cleared low mask bits therefore means a larger ROM window. The mask also decides whether the ROM decode enable bit can be set at all.

The mask comes from a serial EEPROM image through a load port that carries a valid strobe, a data word and an error strobe. After a successful load, a local register port can also rewrite it. Configuration writes reach the base register through a 32-bit data word with four byte enables. The block outputs the base register, the enable bit and the current mask. It also gives a registered hit flag that tells whether an incoming memory address falls inside the claimed window.

Top module: `rom_bar_window`

## Requirements
- R1: During reset and on the first cycle after it, `mask_q`, `bar_q`, `rom_en` and `addr_hit` are all 0.
- R2: An `ee_error` pulse sets the mask to 0 on the following cycle, and takes priority over `ee_valid` in the same cycle. An `ee_valid` pulse stores `ee_data` into the mask on the following cycle.
- R3: A local write (`lw_en`) updates the mask on the following cycle only when a successful EEPROM load has occurred since the last reset or load error. Otherwise it is ignored. An `ee_valid` in the same cycle wins over a local write.
- R4: Mask bits 2 and 1 are reserved. They are stored as 0 whatever value is loaded or written, so they always read as 0 on `mask_q`.
- R5: Mask bit j (j = 3..15) is the write enable for base register bit j+8 (bits 11..23). When the mask bit is 1, a configuration write with the covering byte enable loads that bit. When the mask bit is 0, the base register bit stays at 0.
- R6: Mask bit 0 is the write enable for base register bit 0, the ROM enable. When mask bit 0 is 0, the ROM enable bit is held at 0. `rom_en` always equals `bar_q[0]`.
- R7: Base register bits 31..24 can always be written. Bits 10..1 always read as 0. Byte enable n covers data bits 8n+7 down to 8n, and a bit whose byte enable is 0 keeps its value.
- R8: When the mask changes, every base register bit whose mask bit has just become 0 reads as 0 from the cycle after the mask update.
- R9: `addr_hit` is registered. One cycle after an address is presented, it is 1 exactly when the ROM enable bit is 1 and the address equals `bar_q` on bits 31..24 and on every bit 23..11 whose mask bit is 1. Bits with a mask bit of 0 are not compared.
- R10: Configuration writes made before any EEPROM load leave bits 23..11 and bit 0 at 0. Only bits 31..24 take the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_valid | input | 1 | EEPROM image word for the mask is valid |
| ee_data | input | 16 | EEPROM image mask word |
| ee_error | input | 1 | EEPROM read reported an error |
| lw_en | input | 1 | Local register write of the mask |
| lw_data | input | 16 | Local register write data |
| cfg_we | input | 1 | Configuration write to the base register |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| mem_addr | input | 32 | Memory address to compare with the window |
| bar_q | output | 32 | Current base register value |
| rom_en | output | 1 | ROM decode enable (base register bit 0) |
| mask_q | output | 16 | Current size mask |
| addr_hit | output | 1 | Registered window hit for `mem_addr` |

## Verification
The bench writes all-ones data while the mask is still zero. A design that gated the writes with the loaded data instead of the stored mask would let the low address bits or the enable bit through. It narrows the mask after the register has been written, and a design without the clear-on-narrow step would keep stale address bits that then change the hit decision. It also raises an error after a load and then tries a local write, which catches a design that lets local writes through before or after a failed load. It presents addresses that differ only in masked-off bits and addresses that differ in the upper byte. A comparator that included don't-care bits, or ignored the enable bit, would give the wrong hit flag.

// File: rtl/rombar_pkg.sv
package rombar_pkg;
  typedef enum logic [1:0] {
    MSK_HOLD  = 2'd0,
    MSK_CLEAR = 2'd1,
    MSK_EEPROM = 2'd2,
    MSK_LOCAL = 2'd3
  } mask_src_e;
endpackage

// File: rtl/rombar_mask_reg.sv
module rombar_mask_reg
  import rombar_pkg::*;
#(
  parameter int MASK_W = 16,
  parameter int RSV_HI = 2,
  parameter int RSV_LO = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ee_valid,
  input  logic [MASK_W-1:0] ee_data,
  input  logic              ee_error,
  input  logic              lw_en,
  input  logic [MASK_W-1:0] lw_data,
  output logic [MASK_W-1:0] mask_q
);
  localparam int RSV_N = RSV_HI - RSV_LO + 1;
  localparam logic [MASK_W-1:0] RSV_BITS = MASK_W'(((1 << RSV_N) - 1) << RSV_LO);

  logic      loaded_q;
  mask_src_e src;

  always_comb begin
    if (ee_error)               src = MSK_CLEAR;
    else if (ee_valid)          src = MSK_EEPROM;
    else if (lw_en && loaded_q) src = MSK_LOCAL;
    else                        src = MSK_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      case (src)
        MSK_CLEAR: begin
          mask_q   <= '0;
          loaded_q <= 1'b0;
        end
        MSK_EEPROM: begin
          mask_q   <= ee_data & ~RSV_BITS;
          loaded_q <= 1'b1;
        end
        MSK_LOCAL: mask_q <= lw_data & ~RSV_BITS;
        default:   mask_q <= mask_q;
      endcase
    end
  end
endmodule

// File: rtl/rombar_base_reg.sv
module rombar_base_reg #(
  parameter int BAR_W    = 32,
  parameter int MASK_W   = 16,
  parameter int PROG_LSB = 11,
  parameter int MASK_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] mask,
  input  logic              cfg_we,
  input  logic [BAR_W/8-1:0] cfg_be,
  input  logic [BAR_W-1:0]  cfg_wdata,
  output logic [BAR_W-1:0]  bar_q,
  output logic [BAR_W-1:0]  keep_o
);
  localparam int PROG_W  = MASK_W - MASK_LSB;
  localparam int FIX_LSB = PROG_LSB + PROG_W;

  logic [BAR_W-1:0] keep;
  logic [BAR_W-1:0] wr_vec;
  logic [BAR_W-1:0] bar_d;

  for (genvar i = 0; i < BAR_W; i++) begin : g_bit
    if (i >= FIX_LSB) begin : g_fix
      assign keep[i] = 1'b1;
    end else if (i >= PROG_LSB) begin : g_prog
      assign keep[i] = mask[i - PROG_LSB + MASK_LSB];
    end else if (i == 0) begin : g_en
      assign keep[i] = mask[0];
    end else begin : g_zero
      assign keep[i] = 1'b0;
    end
    assign wr_vec[i] = cfg_we & cfg_be[i/8];
  end

  assign bar_d  = ((cfg_wdata & wr_vec) | (bar_q & ~wr_vec)) & keep;
  assign keep_o = keep;

  always_ff @(posedge clk) begin
    if (rst) bar_q <= '0;
    else     bar_q <= bar_d;
  end
endmodule

// File: rtl/rombar_match.sv
module rombar_match #(
  parameter int BAR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BAR_W-1:0] addr,
  input  logic [BAR_W-1:0] bar,
  input  logic [BAR_W-1:0] keep,
  output logic             hit_q
);
  logic [BAR_W-1:0] care;
  logic             hit_d;

  assign care  = {keep[BAR_W-1:1], 1'b0};
  assign hit_d = bar[0] && (((addr ^ bar) & care) == '0);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_d;
  end
endmodule

// File: rtl/rom_bar_window.sv
module rom_bar_window #(
  parameter int BAR_W    = 32,
  parameter int MASK_W   = 16,
  parameter int PROG_LSB = 11,
  parameter int RSV_HI   = 2,
  parameter int RSV_LO   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ee_valid,
  input  logic [MASK_W-1:0] ee_data,
  input  logic              ee_error,
  input  logic              lw_en,
  input  logic [MASK_W-1:0] lw_data,
  input  logic              cfg_we,
  input  logic [BAR_W/8-1:0] cfg_be,
  input  logic [BAR_W-1:0]  cfg_wdata,
  input  logic [BAR_W-1:0]  mem_addr,
  output logic [BAR_W-1:0]  bar_q,
  output logic              rom_en,
  output logic [MASK_W-1:0] mask_q,
  output logic              addr_hit
);
  localparam int MASK_LSB = RSV_HI + 1;

  logic [BAR_W-1:0] keep;

  rombar_mask_reg #(
    .MASK_W(MASK_W), .RSV_HI(RSV_HI), .RSV_LO(RSV_LO)
  ) u_mask (
    .clk(clk), .rst(rst),
    .ee_valid(ee_valid), .ee_data(ee_data), .ee_error(ee_error),
    .lw_en(lw_en), .lw_data(lw_data),
    .mask_q(mask_q)
  );

  rombar_base_reg #(
    .BAR_W(BAR_W), .MASK_W(MASK_W), .PROG_LSB(PROG_LSB), .MASK_LSB(MASK_LSB)
  ) u_base (
    .clk(clk), .rst(rst), .mask(mask_q),
    .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .bar_q(bar_q), .keep_o(keep)
  );

  rombar_match #(.BAR_W(BAR_W)) u_match (
    .clk(clk), .rst(rst), .addr(mem_addr),
    .bar(bar_q), .keep(keep), .hit_q(addr_hit)
  );

  assign rom_en = bar_q[0];
endmodule

// File: rtl/rom_bar_window_chk.sv
module rom_bar_window_chk (
  input logic        clk,
  input logic        rst,
  input logic        ee_valid,
  input logic [15:0] ee_data,
  input logic        ee_error,
  input logic        lw_en,
  input logic [15:0] lw_data,
  input logic        cfg_we,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] mem_addr,
  input logic [31:0] bar_q,
  input logic        rom_en,
  input logic [15:0] mask_q,
  input logic        addr_hit
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    mask_q[2:1] == 2'b00); // R4
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ee_error |=> mask_q == 16'h0); // R2
  AST_LOAD_STORES: assert property (@(posedge clk) disable iff (rst)
    (ee_valid && !ee_error) |=> mask_q[15:3] == $past(ee_data[15:3])); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    bar_q[10:1] == 10'h0); // R7
  AST_NARROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bar_q[23:11] & ~$past(mask_q[15:3])) == 13'h0); // R8
  AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
    rom_en |-> $past(mask_q[0])); // R6
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> $past(rom_en)); // R9
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_be[3]) |=> $stable(bar_q[31:24])); // R7
endmodule

bind rom_bar_window rom_bar_window_chk u_chk (.*);

// File: tb/rom_bar_window_tb.sv
module rom_bar_window_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ee_valid = 1'b0, ee_error = 1'b0, lw_en = 1'b0, cfg_we = 1'b0;
  logic [15:0] ee_data = '0, lw_data = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, mem_addr = '0;
  logic [31:0] bar_q;
  logic        rom_en, addr_hit;
  logic [15:0] mask_q;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m_bar = '0;
  logic [15:0] m_mask = '0;
  bit          m_loaded = 0;
  logic        m_hit = 0;

  always #2.5 clk = ~clk;

  rom_bar_window u_dut (.*);

  function automatic bit writable(int b, logic [15:0] mk);
    if (b >= 24) return 1;
    if (b >= 11) return mk[b - 8];
    if (b == 0) return mk[0];
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] nb;
    logic        nh;
    nh = m_bar[0];
    for (int b = 1; b < 32; b++)
      if (writable(b, m_mask) && mem_addr[b] != m_bar[b]) nh = 0;
    for (int b = 0; b < 32; b++) begin
      if (!writable(b, m_mask))            nb[b] = 1'b0;
      else if (cfg_we && cfg_be[b/8])      nb[b] = cfg_wdata[b];
      else                                 nb[b] = m_bar[b];
    end
    if (rst) begin
      m_bar = '0; m_mask = '0; m_loaded = 0; m_hit = 0;
    end else begin
      m_bar = nb;
      m_hit = nh;
      if (ee_error) begin m_mask = '0; m_loaded = 0; end
      else if (ee_valid) begin m_mask = ee_data; m_mask[2:1] = 2'b00; m_loaded = 1; end
      else if (lw_en && m_loaded) begin m_mask = lw_data; m_mask[2:1] = 2'b00; end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk({16'h0, mask_q}, {16'h0, m_mask}, "R2 mask model");
      chk(bar_q, m_bar, "R5 bar model");
      chk({31'h0, rom_en}, {31'h0, m_bar[0]}, "R6 rom_en model");
      chk({31'h0, addr_hit}, {31'h0, m_hit}, "R9 hit model");
    end
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    cfg_we = 1; cfg_be = be; cfg_wdata = d; step();
    cfg_we = 0; cfg_be = '0;
  endtask

  task automatic ee_load(input logic [15:0] d);
    ee_valid = 1; ee_data = d; step(); ee_valid = 0;
  endtask

  task automatic lw(input logic [15:0] d);
    lw_en = 1; lw_data = d; step(); lw_en = 0;
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    chk(bar_q, 32'h0, "R1 bar after reset");
    chk({16'h0, mask_q}, 32'h0, "R1 mask after reset");
    chk({30'h0, rom_en, addr_hit}, 32'h0, "R1 en/hit after reset");

    // R3: local write before load ignored
    lw(16'hFFFF);
    chk({16'h0, mask_q}, 32'h0, "R3 local write before load");
    // R10: config writes before load
    cfg_write(4'hF, 32'hFFFF_FFFF);
    chk(bar_q, 32'hFF00_0000, "R10 write before load");

    ee_load(16'hFFFF);
    chk({16'h0, mask_q}, 32'h0000_FFF9, "R4 reserved bits stored 0");
    cfg_write(4'hF, 32'hFFFF_FFFF);
    chk(bar_q, 32'hFFFF_F801, "R5 full mask write");
    chk({31'h0, rom_en}, 32'h1, "R6 enable set");
    cfg_write(4'b1000, 32'h0000_0000);
    chk(bar_q, 32'h00FF_F801, "R7 byte enable lane 3 only");
    cfg_write(4'b0010, 32'h0000_0000);
    chk(bar_q, 32'h00FF_0001, "R7 lane 1 clears 15..11");
    cfg_write(4'b0010, 32'h0000_FFFF);

    // R8: narrow mask to bits 15..12 and 0 (BAR 23..20)
    lw(16'hF001);
    step();
    chk(bar_q, 32'h00F0_0001, "R8 narrowed bits cleared");

    // R9: hit on don't-care differences
    mem_addr = 32'h00F1_2345; step();
    chk({31'h0, addr_hit}, 32'h1, "R9 hit with dont-care bits");
    mem_addr = 32'h01F0_0000; step();
    chk({31'h0, addr_hit}, 32'h0, "R9 miss on top byte");
    mem_addr = 32'h0070_0000; step();
    chk({31'h0, addr_hit}, 32'h0, "R9 miss on masked-in bit 23");

    // R6: drop enable write permission
    mem_addr = 32'h00F0_0000;
    lw(16'hF000);
    step();
    chk({31'h0, rom_en}, 32'h0, "R6 enable forced low");
    step();
    chk({31'h0, addr_hit}, 32'h0, "R9 no hit when disabled");

    // R2: error clears, and precedence over valid
    ee_error = 1; ee_valid = 1; ee_data = 16'hFFFF; step();
    ee_error = 0; ee_valid = 0;
    chk({16'h0, mask_q}, 32'h0, "R2 error wins over load");
    lw(16'hFFFF);
    chk({16'h0, mask_q}, 32'h0, "R3 local write after error");
    step();
    chk(bar_q, 32'h00F0_0000 & 32'hFF00_0000, "R8 error clears address bits");

    // randomized phase compared every cycle
    for (int i = 0; i < 600; i++) begin
      ee_error  = ($urandom_range(0, 40) == 0);
      ee_valid  = ($urandom_range(0, 15) == 0);
      ee_data   = 16'($urandom);
      lw_en     = ($urandom_range(0, 7) == 0);
      lw_data   = 16'($urandom);
      cfg_we    = ($urandom_range(0, 2) == 0);
      cfg_be    = 4'($urandom);
      cfg_wdata = $urandom;
      mem_addr  = ($urandom_range(0, 1) == 0) ? (bar_q ^ (32'($urandom) & 32'h000F_FFFE)) : $urandom;
      step();
    end
    ee_error = 0; ee_valid = 0; lw_en = 0; cfg_we = 0;
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule